// File: doc/BRIEF.md
# Interleaved Memory Window Router

The router serves one fixed window of host memory. A requester presents a read or write at an offset inside the window, 1 to 8 bytes wide and with any alignment. The router adds the window base to the offset to form a host physical address. It then picks one of up to `NPORT` downstream host-bridge ports by interleaving on that address. The request is driven on the chosen port's valid line, over a shared address/data bus. The router waits for the downstream stage to answer, then presents a single response to the requester.

The downstream stage may report that nothing behind the port decodes the address. The router treats that case asymmetrically: a read fails with zero data, and a write is quietly reported as successful. The router handles some requests as misses without touching any port: offsets at or beyond the window size, and any request made before a legal window has been loaded.

Window settings arrive on a one-cycle configuration strobe and carry:
- base address
- size
- target count
- an optional granularity code

Illegal settings raise an error flag and leave the previous window in force.

Top module: `ilvw_router`

## Requirements
- R1: The address driven on `dn_addr` equals the loaded window base plus the request offset, modulo 2^ADDR_W. `dn_write`, `dn_size` and `dn_wdata` repeat the request's fields.
- R2: The selected port index is (host address >> (8 + granularity code)) modulo the target count. Exactly that one bit of `dn_valid` is raised. It stays raised, with the address unchanged, until the same bit of `dn_ready` is seen high.
- R3: When `cfg_gran_en` is 0 during a configuration, the granularity code used is 0 (256-byte granules), whatever `cfg_gran` holds.
- R4: A configuration whose size has any of bits [27:0] set (not a multiple of 256 MiB) sets `cfg_err` on the next cycle. The window already loaded keeps routing unchanged.
- R5: A target count other than 1, 2, 4 or 8 (and at most NPORT), or an enabled granularity code above 6, sets `cfg_err` and is not applied. A legal configuration clears `cfg_err`.
- R6: A read that the downstream stage answers with `dn_rmiss`=1 completes with `rsp_err`=1 and `rsp_rdata` all zero.
- R7: A write always completes with `rsp_err`=0, including when the downstream stage reports a miss.
- R8: A request whose offset is not below the window size, or that arrives before any legal configuration, raises no `dn_valid`. It is answered as a miss (read: error and zero data; write: no error).
- R9: Read data is little-endian. Byte k of `rsp_rdata` (bits 8k+7:8k) is downstream byte k for k < `req_size`, and zero otherwise.
- R10: Only one request is in flight. `req_ready` is low from acceptance until the response is taken, and `rsp_valid`, `rsp_err` and `rsp_rdata` hold steady while `rsp_ready` is low.
- R11: After reset, `req_ready`=1, `dn_valid`=0, `rsp_valid`=0, `cfg_err`=0, and no window is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | One-cycle strobe carrying new window settings |
| cfg_base | input | ADDR_W | Window base host address |
| cfg_size | input | ADDR_W | Window size in bytes |
| cfg_count | input | 4 | Number of interleave targets |
| cfg_gran_en | input | 1 | Granularity code supplied |
| cfg_gran | input | 4 | Granularity code (granule = 256 << code) |
| cfg_err | output | 1 | Last configuration was rejected |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Router can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Window-relative byte offset |
| req_size | input | 4 | Access size in bytes, 1 to 8 |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| dn_valid | output | NPORT | Per-port request valid |
| dn_ready | input | NPORT | Per-port request ready |
| dn_addr | output | ADDR_W | Host physical address |
| dn_write | output | 1 | Downstream request is a write |
| dn_size | output | 4 | Downstream access size |
| dn_wdata | output | 64 | Downstream write data |
| dn_rvalid | input | 1 | Downstream answer for the request in flight |
| dn_rmiss | input | 1 | Downstream found no target for the address |
| dn_rdata | input | 64 | Downstream read data |

## Verification
The assertions take three things for granted about the inputs:
- `req_size` lies between 1 and 8.
- `dn_rvalid` is raised only after the selected port's request handshake, once per request.
- `cfg_valid` is never asserted in the same cycle as reset.

The bench's downstream model answers one cycle after it raises `dn_ready` and returns a single answer. Every vector and directed request uses sizes from 1 to 8. Configuration strobes are issued only between requests, once reset has been released.

// File: rtl/ilvw_pkg.sv
package ilvw_pkg;

    localparam int DATA_W          = 64;
    localparam int GRAN_BASE_SHIFT = 8;   // 256-byte minimum granule
    localparam int GRAN_MAX_CODE   = 6;   // 16 KiB largest granule
    localparam int WIN_ALIGN_BITS  = 28;  // 256 MiB window size unit

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RESP
    } ctrl_state_e;

    typedef struct packed {
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    // Byte lanes kept for an access of nbytes, lowest lanes first.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [3:0] nbytes);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W / 8; b++) begin
            if (b < int'(nbytes)) m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic count_legal(input logic [3:0] cnt, input int max_ports);
        return (cnt != 4'd0) && ((cnt & (cnt - 4'd1)) == 4'd0) && (int'(cnt) <= max_ports);
    endfunction

    function automatic logic gran_legal(input logic [3:0] code);
        return int'(code) <= GRAN_MAX_CODE;
    endfunction

endpackage

// File: rtl/ilvw_cfg.sv
module ilvw_cfg
    import ilvw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NPORT  = 8,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_size,
    input  logic [3:0]        cfg_count,
    input  logic              cfg_gran_en,
    input  logic [3:0]        cfg_gran,
    output logic              win_on,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] size_q,
    output logic [2:0]        gran_q,
    output logic [PORT_W-1:0] mask_q,
    output logic              cfg_err
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << WIN_ALIGN_BITS) - 64'd1);

    logic       size_ok;
    logic       legal;
    logic [2:0] gran_eff;

    always_comb begin
        size_ok  = (cfg_size & ALIGN_MASK) == '0;
        legal    = size_ok && count_legal(cfg_count, NPORT) &&
                   (!cfg_gran_en || gran_legal(cfg_gran));
        gran_eff = cfg_gran_en ? cfg_gran[2:0] : 3'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_on  <= 1'b0;
            base_q  <= '0;
            size_q  <= '0;
            gran_q  <= '0;
            mask_q  <= '0;
            cfg_err <= 1'b0;
        end else if (cfg_valid) begin
            if (legal) begin
                win_on  <= 1'b1;
                base_q  <= cfg_base;
                size_q  <= cfg_size;
                gran_q  <= gran_eff;
                mask_q  <= PORT_W'(cfg_count - 4'd1);
                cfg_err <= 1'b0;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ilvw_decode.sv
module ilvw_decode
    import ilvw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PORT_W = 3
) (
    input  logic              win_on,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] size,
    input  logic [2:0]        gran,
    input  logic [PORT_W-1:0] mask,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] hpa,
    output logic              hit,
    output logic [PORT_W-1:0] port
);

    always_comb begin
        hpa  = base + offset;
        hit  = win_on && (offset < size);
        // Power-of-two target count: modulo reduces to a mask.
        port = PORT_W'(hpa >> (GRAN_BASE_SHIFT + int'(gran))) & mask;
    end

endmodule

// File: rtl/ilvw_ctrl.sv
module ilvw_ctrl
    import ilvw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NPORT  = 8,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [3:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] dec_hpa,
    input  logic              dec_hit,
    input  logic [PORT_W-1:0] dec_port,
    output logic [NPORT-1:0]  dn_valid,
    input  logic [NPORT-1:0]  dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [3:0]        dn_size,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic              dn_rvalid,
    input  logic              dn_rmiss,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    ctrl_state_e       state;
    logic [ADDR_W-1:0] hpa_q;
    logic              wr_q;
    logic [3:0]        size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [PORT_W-1:0] port_q;
    rsp_t              rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hpa_q   <= '0;
            wr_q    <= 1'b0;
            size_q  <= '0;
            wdata_q <= '0;
            port_q  <= '0;
            rsp_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    hpa_q   <= dec_hpa;
                    wr_q    <= req_write;
                    size_q  <= req_size;
                    wdata_q <= req_wdata;
                    port_q  <= dec_port;
                    if (dec_hit) begin
                        state <= ST_SEND;
                    end else begin
                        rsp_q.err  <= ~req_write;
                        rsp_q.data <= '0;
                        state      <= ST_RESP;
                    end
                end
                ST_SEND: if (dn_ready[port_q]) state <= ST_WAIT;
                ST_WAIT: if (dn_rvalid) begin
                    rsp_q.err  <= dn_rmiss & ~wr_q;
                    rsp_q.data <= (dn_rmiss || wr_q) ? '0 : (dn_rdata & lane_mask(size_q));
                    state      <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        dn_valid  = (state == ST_SEND) ? (NPORT'(1) << port_q) : '0;
        dn_addr   = hpa_q;
        dn_write  = wr_q;
        dn_size   = size_q;
        dn_wdata  = wdata_q;
        rsp_valid = (state == ST_RESP);
        rsp_err   = rsp_q.err;
        rsp_rdata = rsp_q.data;
    end

endmodule

// File: rtl/ilvw_router.sv
module ilvw_router
    import ilvw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int NPORT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_size,
    input  logic [3:0]        cfg_count,
    input  logic              cfg_gran_en,
    input  logic [3:0]        cfg_gran,
    output logic              cfg_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic [NPORT-1:0]  dn_valid,
    input  logic [NPORT-1:0]  dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [3:0]        dn_size,
    output logic [63:0]       dn_wdata,
    input  logic              dn_rvalid,
    input  logic              dn_rmiss,
    input  logic [63:0]       dn_rdata
);

    localparam int PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1;

    logic              win_on;
    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W-1:0] win_size;
    logic [2:0]        win_gran;
    logic [PORT_W-1:0] win_mask;
    logic [ADDR_W-1:0] dec_hpa;
    logic              dec_hit;
    logic [PORT_W-1:0] dec_port;

    ilvw_cfg #(.ADDR_W(ADDR_W), .NPORT(NPORT), .PORT_W(PORT_W)) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_count(cfg_count), .cfg_gran_en(cfg_gran_en), .cfg_gran(cfg_gran),
        .win_on(win_on), .base_q(win_base), .size_q(win_size),
        .gran_q(win_gran), .mask_q(win_mask), .cfg_err(cfg_err)
    );

    ilvw_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_dec (
        .win_on(win_on), .base(win_base), .size(win_size), .gran(win_gran),
        .mask(win_mask), .offset(req_offset),
        .hpa(dec_hpa), .hit(dec_hit), .port(dec_port)
    );

    ilvw_ctrl #(.ADDR_W(ADDR_W), .NPORT(NPORT), .PORT_W(PORT_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_wdata(req_wdata),
        .dec_hpa(dec_hpa), .dec_hit(dec_hit), .dec_port(dec_port),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_write(dn_write), .dn_size(dn_size), .dn_wdata(dn_wdata),
        .dn_rvalid(dn_rvalid), .dn_rmiss(dn_rmiss), .dn_rdata(dn_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/ilvw_router_chk.sv
module ilvw_router_chk #(
    parameter int ADDR_W = 48,
    parameter int NPORT  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_valid,
    input logic [ADDR_W-1:0] cfg_size,
    input logic              cfg_err,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [3:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic [NPORT-1:0]  dn_valid,
    input logic [NPORT-1:0]  dn_ready,
    input logic [ADDR_W-1:0] dn_addr
);

    localparam logic [ADDR_W-1:0] UNIT_MASK = ADDR_W'((64'd1 << 28) - 64'd1);

    logic       wr_seen;
    logic [3:0] size_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen   <= 1'b0;
            size_seen <= 4'd8;
        end else if (req_valid && req_ready) begin
            wr_seen   <= req_write;
            size_seen <= req_size;
        end
    end

    p_one_port_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_valid));

    p_port_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (|dn_valid && !(|(dn_valid & dn_ready))) |=> ($stable(dn_valid) && $stable(dn_addr)));

    p_bad_size_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && ((cfg_size & UNIT_MASK) != '0)) |=> cfg_err);

    p_read_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0));

    p_write_ok_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && wr_seen) |-> !rsp_err);

    p_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_rdata >> {size_seen, 3'b000}) == 64'd0 || size_seen >= 4'd8));

    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || |dn_valid) |-> !req_ready);

    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_rdata)));

endmodule

bind ilvw_router ilvw_router_chk #(.ADDR_W(ADDR_W), .NPORT(NPORT)) u_chk (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_size(cfg_size),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr)
);

// File: tb/ilvw_router_test.sv
`timescale 1ns/1ps
module ilvw_router_test;

    localparam int AW = 48;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_size = '0;
    logic [3:0]    cfg_count = '0;
    logic          cfg_gran_en = 1'b0;
    logic [3:0]    cfg_gran = '0;
    logic          cfg_err;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [3:0]    req_size = 4'd8;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic          rsp_err;
    logic [63:0]   rsp_rdata;
    logic [NP-1:0] dn_valid;
    logic [NP-1:0] dn_ready = '0;
    logic [AW-1:0] dn_addr;
    logic          dn_write;
    logic [3:0]    dn_size;
    logic [63:0]   dn_wdata;
    logic          dn_rvalid = 1'b0;
    logic          dn_rmiss = 1'b0;
    logic [63:0]   dn_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [AW-1:0] cur_base = '0;

    always #2.5 clk = ~clk;

    ilvw_router #(.ADDR_W(AW), .NPORT(NP)) uut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected below 50000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic configure(input logic [AW-1:0] b, input logic [AW-1:0] s,
                             input logic [3:0] cnt, input logic gen, input logic [3:0] g,
                             input logic exp_err, input string rq);
        @(negedge clk);
        cfg_base = b; cfg_size = s; cfg_count = cnt; cfg_gran_en = gen; cfg_gran = g;
        cfg_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(cfg_err == exp_err, rq, "cfg_err", 64'(cfg_err), 64'(exp_err));
        if (!exp_err) cur_base = b;
    endtask

    task automatic do_req(input logic wr, input logic [AW-1:0] off, input logic [3:0] sz,
                          input logic [63:0] wd, input logic [63:0] dnd, input logic miss,
                          input int exp_port, input logic exp_err, input logic [63:0] exp_rd,
                          input int hold, input string rq);
        int got;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "req_ready idle", 64'(req_ready), 64'd1);
        req_write = wr; req_offset = off; req_size = sz; req_wdata = wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (|dn_valid) begin
            got = -1;
            for (int p = 0; p < NP; p++) if (dn_valid[p]) got = p;
            chk(got == exp_port, (exp_port < 0) ? "R8" : "R2", "port", 64'(got), 64'(exp_port));
            chk(dn_addr == cur_base + off, "R1", "dn_addr", 64'(dn_addr), 64'(cur_base + off));
            chk(dn_write == wr && dn_size == sz && (!wr || dn_wdata == wd), "R1", "fields",
                {dn_write, dn_size, 59'd0}, {wr, sz, 59'd0});
            @(negedge clk);
            chk(dn_valid == NP'(1) << got, "R2", "valid held", 64'(dn_valid), 64'(NP'(1) << got));
            dn_ready = '1;
            @(posedge clk);
            @(negedge clk);
            dn_ready = '0; dn_rvalid = 1'b1; dn_rdata = dnd; dn_rmiss = miss;
            @(posedge clk);
            @(negedge clk);
            dn_rvalid = 1'b0; dn_rmiss = 1'b0;
        end else begin
            chk(exp_port < 0, "R8", "no port raised", 64'd0, 64'(exp_port));
        end
        for (int h = 0; h < hold; h++) begin
            chk(rsp_valid && !req_ready, "R10", "busy hold", {rsp_valid, req_ready}, 64'd2);
            @(negedge clk);
        end
        chk(rsp_valid == 1'b1, "R10", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_err == exp_err, rq, "rsp_err", 64'(rsp_err), 64'(exp_err));
        chk(rsp_rdata == exp_rd, rq, "rsp_rdata", rsp_rdata, exp_rd);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R10", "return idle", {rsp_valid, req_ready}, 64'd1);
    endtask

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] off;
        logic [3:0]    sz;
        logic [63:0]   dnd;
        logic          miss;
        int            port;
        logic          err;
        logic [63:0]   rd;
    } vec_t;

    // Window: base 0x4000_0000, size 512 MiB, 4 targets, 512-byte granules.
    localparam vec_t VECS [9] = '{
        '{1'b0, 48'h0000_0000_0000, 4'd8, 64'h1122_3344_5566_7788, 1'b0, 0, 1'b0, 64'h1122_3344_5566_7788},
        '{1'b0, 48'h0000_0000_0200, 4'd4, 64'hAABB_CCDD_EEFF_0011, 1'b0, 1, 1'b0, 64'h0000_0000_EEFF_0011},
        '{1'b1, 48'h0000_0000_0400, 4'd2, 64'h0,                   1'b0, 2, 1'b0, 64'h0},
        '{1'b0, 48'h0000_0000_07FF, 4'd1, 64'h1234_5678_9ABC_DEF0, 1'b0, 3, 1'b0, 64'h0000_0000_0000_00F0},
        '{1'b0, 48'h0000_0000_0800, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, 1'b1, 64'h0},
        '{1'b1, 48'h0000_0000_0A00, 4'd8, 64'h0,                   1'b1, 1, 1'b0, 64'h0},
        '{1'b0, 48'h0000_1FFF_FFF8, 4'd8, 64'h0102_0304_0506_0708, 1'b0, 3, 1'b0, 64'h0102_0304_0506_0708},
        '{1'b0, 48'h0000_2000_0000, 4'd8, 64'h0,                   1'b0, -1, 1'b1, 64'h0},
        '{1'b1, 48'h0000_3000_0000, 4'd4, 64'h0,                   1'b0, -1, 1'b0, 64'h0}
    };

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk(req_ready && !rsp_valid && dn_valid == '0 && !cfg_err, "R11", "reset state",
            {req_ready, rsp_valid, cfg_err, 53'd0, dn_valid}, {1'b1, 63'd0});

        // R8: no window loaded yet
        do_req(1'b0, 48'h0, 4'd8, 64'h0, 64'h0, 1'b0, -1, 1'b1, 64'h0, 0, "R8");
        do_req(1'b1, 48'h0, 4'd8, 64'h5, 64'h0, 1'b0, -1, 1'b0, 64'h0, 0, "R8");

        configure(48'h0000_4000_0000, 48'h0000_2000_0000, 4'd4, 1'b1, 4'd1, 1'b0, "R5");
        for (int i = 0; i < 9; i++) begin
            if (VECS[i].port < 0)                 tag = "R8";
            else if (VECS[i].wr)                  tag = "R7";
            else if (VECS[i].miss)                tag = "R6";
            else                                  tag = "R9";
            do_req(VECS[i].wr, VECS[i].off, VECS[i].sz, 64'hC0DE_0000_0000_0000 | 64'(i),
                   VECS[i].dnd, VECS[i].miss, VECS[i].port, VECS[i].err, VECS[i].rd,
                   (i == 1) ? 2 : 0, tag);
        end

        // R4: unaligned size rejected, previous window stays in force
        configure(48'h0, 48'h0000_1000_0100, 4'd2, 1'b0, 4'd0, 1'b1, "R4");
        do_req(1'b0, 48'h400, 4'd8, 64'h0, 64'h0BAD_F00D_0BAD_F00D, 1'b0, 2, 1'b0,
               64'h0BAD_F00D_0BAD_F00D, 0, "R4");
        // R5: bad count / bad granularity code
        configure(48'h0, 48'h0000_1000_0000, 4'd3, 1'b0, 4'd0, 1'b1, "R5");
        configure(48'h0, 48'h0000_1000_0000, 4'd2, 1'b1, 4'd7, 1'b1, "R5");
        configure(48'h0, 48'h0000_1000_0000, 4'd0, 1'b0, 4'd0, 1'b1, "R5");

        // R3: granularity not supplied -> 256-byte granules
        configure(48'h0, 48'h0000_1000_0000, 4'd2, 1'b0, 4'd5, 1'b0, "R5");
        do_req(1'b0, 48'h100, 4'd8, 64'h0, 64'h77, 1'b0, 1, 1'b0, 64'h77, 0, "R3");
        do_req(1'b0, 48'h200, 4'd8, 64'h66, 64'h66, 1'b0, 0, 1'b0, 64'h66, 0, "R3");

        // R2: eight targets, 16 KiB granules, with response backpressure
        configure(48'h0, 48'h0000_1000_0000, 4'd8, 1'b1, 4'd6, 1'b0, "R5");
        do_req(1'b0, 48'h14000, 4'd8, 64'h0, 64'h55, 1'b0, 5, 1'b0, 64'h55, 3, "R2");
        do_req(1'b1, 48'h3C000, 4'd8, 64'h99, 64'h0, 1'b0, 7, 1'b0, 64'h0, 1, "R2");

        // R9: single target, three-byte read, base nonzero
        configure(48'h0000_0123_4567, 48'h0000_1000_0000, 4'd1, 1'b1, 4'd0, 1'b0, "R5");
        do_req(1'b0, 48'h12345, 4'd3, 64'h0, 64'hFFEE_DDCC_BBAA_9988, 1'b0, 0, 1'b0,
               64'h0000_0000_00AA_9988, 0, "R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule